// File: doc/BRIEF.md
# Operand Forwarding Selection Unit

This combinational block sits in the execute stage of a five-stage in-order pipeline and picks the two ALU operands, plus the value to be stored, for the instruction currently held between decode and execute. The register-file values read in decode may be stale when an older instruction that writes the same register is still in flight. The block compares the current instruction's two source register fields against the destination of each of the three older instructions held in the later pipeline registers (execute/memory, memory/writeback and the writeback/end register that holds the instruction retired one cycle earlier). On a match it substitutes the newer value.

Each older instruction's destination depends on its opcode. Arithmetic instructions write the register named in their low bits. A load writes the register named in its second source field. Every other opcode writes nothing. A load sitting in the execute/memory register only has an address as its result, so it is never a forwarding source there; resolving that case belongs to separate stall logic.

The pipeline feeds in the four instruction words and the candidate values. It takes back operand A, operand B and the store data.

Top module: `fwd_unit`

## Requirements
- R1: Instruction fields are: opcode at bits 24:22, first source (src1) at bits 21:19, second source (src2) at bits 18:16, arithmetic destination at bits 2:0. Opcodes are add=000, nor=001, load=010, store=011, branch-equal=100, halt=110, noop=111; 101 is unused. Operand A takes the newest value of register src1 from any of the three older stages.
- R2: When more than one older stage writes the same register, the youngest wins: execute/memory first, then memory/writeback, then writeback/end.
- R3: Only add, nor and load are writers. An older store, branch, halt, noop or unused opcode never causes substitution.
- R4: For an older add or nor, the written register is bits 2:0. Its bits 18:16 are not treated as a destination.
- R5: For an older load, the written register is its src2 field (bits 18:16). Its bits 2:0 are not treated as a destination.
- R6: A load in the execute/memory register is never a source. The choice falls through to memory/writeback, then to writeback/end, then to the register read.
- R7: Operand B equals the offset input when the current opcode is load or store. Otherwise it is the forwarded value of register src2.
- R8: The store value is always the forwarded value of register src2, whatever the current opcode.
- R9: When no older stage matches, the operands pass the decode-stage register reads through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idexInstr | input | 32 | Instruction word held between decode and execute |
| exmemInstr | input | 32 | Instruction word held between execute and memory |
| memwbInstr | input | 32 | Instruction word held between memory and writeback |
| wbendInstr | input | 32 | Instruction retired in the previous cycle |
| idexRegA | input | 32 | Register-file read of src1 taken in decode |
| idexRegB | input | 32 | Register-file read of src2 taken in decode |
| idexOffset | input | 32 | Sign-extended offset of the current instruction |
| exmemAluResult | input | 32 | ALU result held between execute and memory |
| memwbWriteData | input | 32 | Write-back data held between memory and writeback |
| wbendWriteData | input | 32 | Write-back data of the previously retired instruction |
| aluOperandA | output | 32 | Resolved first ALU operand |
| aluOperandB | output | 32 | Resolved second ALU operand |
| storeValue | output | 32 | Resolved store data |

## Verification
A sweep covers all eight current opcodes crossed with every pair of source registers. For each combination, the three older instructions are drawn from a pseudo-random stream that mixes writers and non-writers, and every candidate value is distinct, so a wrong source, a wrong priority or a wrong destination field shows up as a mismatched value. Directed patterns then place one producer at distance 1, 2 and 3. Other patterns stack producers to separate the priority order. An add is given a decoy in its src2 bits and a load a decoy in its low bits, to tell the two destination rules apart. A non-writer is placed between the producer and its consumer, and a load sits in execute/memory over an older writer, which shows that the result falls through instead of being forwarded.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  localparam int NUM_SRC = 3;   // older stages: 0 = EX/MEM, 1 = MEM/WB, 2 = WB/END
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'b000,
    OP_NOR  = 3'b001,
    OP_LW   = 3'b010,
    OP_SW   = 3'b011,
    OP_BEQ  = 3'b100,
    OP_HALT = 3'b110,
    OP_NOOP = 3'b111
  } opcode_e;

  // Strobes from control to datapath: one-hot0 source picks per operand.
  typedef struct packed {
    logic [NUM_SRC-1:0] pickA;
    logic [NUM_SRC-1:0] pickB;
    logic               useOffset;
  } fwdSel_t;
endpackage

// File: rtl/fwd_ctrl.sv
`timescale 1ns/1ps
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int INSTR_W  = 32,
  parameter int IDX_W    = 3,
  parameter int OP_LSB   = 22,
  parameter int SRC1_LSB = 19,
  parameter int SRC2_LSB = 16,
  parameter int DEST_LSB = 0
) (
  input  logic [INSTR_W-1:0]              idexInstr,
  input  logic [NUM_SRC-1:0][INSTR_W-1:0] olderInstr,
  output fwdSel_t                         sel
);
  localparam int ADDR_ONLY_STAGE = 0;  // a load here holds an address, not data

  logic [IDX_W-1:0]   src1, src2;
  opcode_e            curOp;
  logic [NUM_SRC-1:0] hitA, hitB;
  logic               unusedInstrBits;

  assign curOp = opcode_e'(idexInstr[OP_LSB +: OP_W]);
  assign src1  = idexInstr[SRC1_LSB +: IDX_W];
  assign src2  = idexInstr[SRC2_LSB +: IDX_W];
  assign unusedInstrBits = ^{idexInstr, olderInstr};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_stage
    opcode_e          op;
    logic             writer;
    logic [IDX_W-1:0] dest;

    assign op = opcode_e'(olderInstr[s][OP_LSB +: OP_W]);

    if (s == ADDR_ONLY_STAGE) begin : g_no_load
      assign writer = (op == OP_ADD) || (op == OP_NOR);
    end else begin : g_with_load
      assign writer = (op == OP_ADD) || (op == OP_NOR) || (op == OP_LW);
    end

    assign dest = (op == OP_LW) ? olderInstr[s][SRC2_LSB +: IDX_W]
                                : olderInstr[s][DEST_LSB +: IDX_W];

    assign hitA[s] = writer && (dest == src1);
    assign hitB[s] = writer && (dest == src2);
  end

  // Keep only the lowest-index (youngest) hit.
  function automatic logic [NUM_SRC-1:0] youngestHit(input logic [NUM_SRC-1:0] raw);
    logic [NUM_SRC-1:0] res;
    logic taken;
    res   = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (raw[i] && !taken) begin
        res[i] = 1'b1;
        taken  = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb begin
    sel.pickA     = youngestHit(hitA);
    sel.pickB     = youngestHit(hitB);
    sel.useOffset = (curOp == OP_LW) || (curOp == OP_SW);
  end
endmodule

// File: rtl/fwd_datapath.sv
`timescale 1ns/1ps
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdSel_t                        sel,
  input  logic [DATA_W-1:0]              regAVal,
  input  logic [DATA_W-1:0]              regBVal,
  input  logic [DATA_W-1:0]              offsetVal,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] fwdVal,
  output logic [DATA_W-1:0]              opA,
  output logic [DATA_W-1:0]              opB,
  output logic [DATA_W-1:0]              storeVal
);
  logic [DATA_W-1:0] fwdA, fwdB;

  // AND-OR mux: picks are one-hot0, the register read fills the empty case.
  always_comb begin
    fwdA = (sel.pickA == '0) ? regAVal : '0;
    fwdB = (sel.pickB == '0) ? regBVal : '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      fwdA = fwdA | ({DATA_W{sel.pickA[s]}} & fwdVal[s]);
      fwdB = fwdB | ({DATA_W{sel.pickB[s]}} & fwdVal[s]);
    end
  end

  assign opA      = fwdA;
  assign opB      = sel.useOffset ? offsetVal : fwdB;
  assign storeVal = fwdB;
endmodule

// File: rtl/fwd_unit.sv
`timescale 1ns/1ps
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 3
) (
  input  logic [INSTR_W-1:0] idexInstr,
  input  logic [INSTR_W-1:0] exmemInstr,
  input  logic [INSTR_W-1:0] memwbInstr,
  input  logic [INSTR_W-1:0] wbendInstr,
  input  logic [DATA_W-1:0]  idexRegA,
  input  logic [DATA_W-1:0]  idexRegB,
  input  logic [DATA_W-1:0]  idexOffset,
  input  logic [DATA_W-1:0]  exmemAluResult,
  input  logic [DATA_W-1:0]  memwbWriteData,
  input  logic [DATA_W-1:0]  wbendWriteData,
  output logic [DATA_W-1:0]  aluOperandA,
  output logic [DATA_W-1:0]  aluOperandB,
  output logic [DATA_W-1:0]  storeValue
);
  logic [NUM_SRC-1:0][INSTR_W-1:0] olderInstr;
  logic [NUM_SRC-1:0][DATA_W-1:0]  olderVal;
  fwdSel_t                         sel;

  assign olderInstr = {wbendInstr, memwbInstr, exmemInstr};
  assign olderVal   = {wbendWriteData, memwbWriteData, exmemAluResult};

  fwd_ctrl #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_ctrl (
    .idexInstr (idexInstr),
    .olderInstr(olderInstr),
    .sel       (sel)
  );

  fwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .sel      (sel),
    .regAVal  (idexRegA),
    .regBVal  (idexRegB),
    .offsetVal(idexOffset),
    .fwdVal   (olderVal),
    .opA      (aluOperandA),
    .opB      (aluOperandB),
    .storeVal (storeValue)
  );
endmodule

// File: rtl/fwd_unit_chk.sv
`timescale 1ns/1ps
module fwd_unit_chk
  import fwd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32
) (
  input logic [INSTR_W-1:0] idexInstr,
  input logic [INSTR_W-1:0] exmemInstr,
  input logic [DATA_W-1:0]  idexRegA,
  input logic [DATA_W-1:0]  idexOffset,
  input logic [DATA_W-1:0]  aluOperandA,
  input logic [DATA_W-1:0]  aluOperandB,
  input logic [DATA_W-1:0]  storeValue,
  input fwdSel_t            sel
);
  logic [OP_W-1:0] curOp, ymOp;
  logic            unusedBits;

  assign curOp      = idexInstr[22 +: OP_W];
  assign ymOp       = exmemInstr[22 +: OP_W];
  assign unusedBits = ^{idexInstr, exmemInstr};

  always_comb begin
    p_one_source_a_r2: assert ($onehot0(sel.pickA))
      else $error("operand A picks more than one source");
    p_one_source_b_r2: assert ($onehot0(sel.pickB))
      else $error("operand B picks more than one source");
    p_nonwriter_ignored_r3: assert (!(sel.pickA[0] && ymOp != OP_ADD && ymOp != OP_NOR))
      else $error("non-writer in EX/MEM used as source");
    p_load_addr_not_fwd_r6: assert (!((sel.pickA[0] || sel.pickB[0]) && ymOp == OP_LW))
      else $error("load address forwarded from EX/MEM");
    p_offset_operand_r7: assert (!(curOp == OP_LW || curOp == OP_SW) || aluOperandB == idexOffset)
      else $error("offset not used for memory instruction");
    p_store_chain_r8: assert (sel.useOffset || storeValue == aluOperandB)
      else $error("store value differs from forwarded src2");
    p_pass_through_r9: assert (sel.pickA != '0 || aluOperandA == idexRegA)
      else $error("operand A altered without a match");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_chk (
  .idexInstr  (idexInstr),
  .exmemInstr (exmemInstr),
  .idexRegA   (idexRegA),
  .idexOffset (idexOffset),
  .aluOperandA(aluOperandA),
  .aluOperandB(aluOperandB),
  .storeValue (storeValue),
  .sel        (sel)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;
  localparam logic [2:0] ADD = 3'b000, NOR = 3'b001, LW = 3'b010, SW = 3'b011,
                         BEQ = 3'b100, HALT = 3'b110, NOOP = 3'b111;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] idexInstr, exmemInstr, memwbInstr, wbendInstr;
  logic [31:0] idexRegA, idexRegB, idexOffset;
  logic [31:0] exmemAluResult, memwbWriteData, wbendWriteData;
  logic [31:0] aluOperandA, aluOperandB, storeValue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1BADF00D;

  fwd_unit dut (.*);

  function automatic logic [31:0] mk(logic [2:0] op, logic [2:0] a, logic [2:0] b, logic [2:0] d);
    return {7'd0, op, a, b, 13'd0, d};
  endfunction

  // Does instr write register idx? allowLw=0 for the EX/MEM slot.
  function automatic bit writes(logic [31:0] ins, logic [2:0] idx, bit allowLw);
    logic [2:0] op;
    op = ins[24:22];
    if (op == ADD || op == NOR) return ins[2:0] == idx;
    if (op == LW && allowLw)    return ins[18:16] == idx;
    return 1'b0;
  endfunction

  function automatic logic [31:0] expectFwd(logic [2:0] idx, logic [31:0] base);
    logic [31:0] r;
    r = base;
    if (writes(wbendInstr, idx, 1'b1)) r = wbendWriteData;
    if (writes(memwbInstr, idx, 1'b1)) r = memwbWriteData;
    if (writes(exmemInstr, idx, 1'b0)) r = exmemAluResult;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setVals(logic [31:0] seed);
    idexRegA       = 32'hAA00_0000 ^ seed;
    idexRegB       = 32'hBB00_0000 ^ seed;
    idexOffset     = 32'h0FF0_0000 ^ seed;
    exmemAluResult = 32'h1100_0000 ^ seed;
    memwbWriteData = 32'h2200_0000 ^ seed;
    wbendWriteData = 32'h3300_0000 ^ seed;
  endtask

  task automatic apply(logic [31:0] cur, logic [31:0] s0, logic [31:0] s1, logic [31:0] s2);
    @(posedge clk);
    idexInstr = cur; exmemInstr = s0; memwbInstr = s1; wbendInstr = s2;
    @(negedge clk);
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] nop;
    nop = mk(NOOP, 0, 0, 0);
    setVals(32'h0);

    // R9: idle pipeline, reads pass through
    apply(mk(ADD, 3'd1, 3'd2, 3'd0), nop, nop, nop);
    check("R9 idle opA", aluOperandA, idexRegA);
    check("R9 idle opB", aluOperandB, idexRegB);
    check("R9 idle store", storeValue, idexRegB);

    // R1/R4: distance 1, 2, 3 on src1
    apply(mk(ADD, 3'd3, 3'd0, 3'd0), mk(ADD, 0, 0, 3'd3), nop, nop);
    check("R1 dist1 opA", aluOperandA, exmemAluResult);
    apply(mk(ADD, 3'd3, 3'd0, 3'd0), nop, mk(NOR, 0, 0, 3'd3), nop);
    check("R1 dist2 opA", aluOperandA, memwbWriteData);
    apply(mk(ADD, 3'd3, 3'd0, 3'd0), nop, nop, mk(ADD, 0, 0, 3'd3));
    check("R1 dist3 opA", aluOperandA, wbendWriteData);

    // R3: non-writers in between, producer at distance 3
    apply(mk(NOR, 3'd2, 3'd5, 3'd0), mk(SW, 0, 3'd2, 3'd2), mk(BEQ, 3'd2, 3'd2, 3'd2),
          mk(ADD, 0, 0, 3'd2));
    check("R3 nonwriter between opA", aluOperandA, wbendWriteData);
    apply(mk(NOR, 3'd2, 3'd5, 3'd0), mk(HALT, 0, 3'd2, 3'd2), mk(3'b101, 3'd2, 3'd2, 3'd2), nop);
    check("R3 only nonwriters opA", aluOperandA, idexRegA);

    // R2: priority
    apply(mk(ADD, 3'd4, 3'd4, 3'd0), mk(ADD, 0, 0, 3'd4), mk(NOR, 0, 0, 3'd4), mk(LW, 0, 3'd4, 0));
    check("R2 all three opA", aluOperandA, exmemAluResult);
    check("R2 all three opB", aluOperandB, exmemAluResult);
    apply(mk(ADD, 3'd4, 3'd1, 3'd0), nop, mk(NOR, 0, 0, 3'd4), mk(ADD, 0, 0, 3'd4));
    check("R2 older two opA", aluOperandA, memwbWriteData);

    // R4: add's src2 bits are not its destination
    apply(mk(ADD, 3'd6, 3'd0, 3'd0), mk(ADD, 0, 3'd6, 3'd1), nop, nop);
    check("R4 decoy src2 opA", aluOperandA, idexRegA);

    // R5: load destination is src2 field
    apply(mk(ADD, 3'd7, 3'd0, 3'd0), nop, mk(LW, 3'd1, 3'd7, 3'd0), nop);
    check("R5 load dest opA", aluOperandA, memwbWriteData);
    check("R5 load low bits not dest opB", aluOperandB, idexRegB);

    // R6: load in EX/MEM falls through
    apply(mk(ADD, 3'd2, 3'd2, 3'd0), mk(LW, 0, 3'd2, 0), nop, mk(ADD, 0, 0, 3'd2));
    check("R6 fallthrough opA", aluOperandA, wbendWriteData);
    apply(mk(ADD, 3'd2, 3'd0, 3'd0), mk(LW, 0, 3'd2, 0), nop, nop);
    check("R6 no source opA", aluOperandA, idexRegA);

    // R7/R8: store uses offset for B, forwarded src2 for data
    apply(mk(SW, 3'd1, 3'd3, 3'd0), mk(ADD, 0, 0, 3'd3), nop, nop);
    check("R7 store opB", aluOperandB, idexOffset);
    check("R8 store data", storeValue, exmemAluResult);
    apply(mk(BEQ, 3'd1, 3'd3, 3'd0), mk(ADD, 0, 0, 3'd3), nop, nop);
    check("R7 beq opB", aluOperandB, exmemAluResult);

    // Sweep: every current opcode x src1 x src2, pseudo-random older stages
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          logic [31:0] s0, s1, s2, r, cur;
          setVals(nextRand() & 32'h00FF_FFFF);
          r  = nextRand(); s0 = mk(r[2:0], r[5:3], r[8:6], r[11:9]);
          r  = nextRand(); s1 = mk(r[2:0], r[5:3], r[8:6], r[11:9]);
          r  = nextRand(); s2 = mk(r[2:0], r[5:3], r[8:6], r[11:9]);
          cur = mk(3'(op), 3'(a), 3'(b), 3'd0);
          apply(cur, s0, s1, s2);
          check("R2 sweep opA", aluOperandA, expectFwd(3'(a), idexRegA));
          check("R7 sweep opB", aluOperandB,
                (3'(op) == LW || 3'(op) == SW) ? idexOffset : expectFwd(3'(b), idexRegB));
          check("R8 sweep store", storeValue, expectFwd(3'(b), idexRegB));
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule